// File: doc/BRIEF.md
# ADC Conversion Start Trigger Controller

This block decides the cycle in which a single-shot analog-to-digital conversion begins. A control word carries four things: a 3-bit start code, an edge-polarity bit, a burst bit and a channel number. The start code picks the start source. The conversion can start at once on a software command, or it can wait for the chosen edge on one of six hardware trigger lines. Two of these lines are external pins and four are timer match outputs. When the chosen event occurs, the block issues a one-cycle start pulse to a converter model that has a fixed latency.

Each finished result goes to two places: a single global result register and the data register of the channel that was converted. Every register has a done flag and an overrun flag. A read strobe clears both flags. Because the channel registers are separate, a result taken under hardware triggering stays readable even after a later conversion on another channel has replaced the global register.

While the burst bit is set, the start code is ignored. Continuous scanning is not built.

Top module: `adc_start_ctl`

## Requirements
- R1: After reset, no start pulse is issued, busy is low, the start code reads 0, and every done and overrun flag in the global register and all channel registers is 0.
- R2: A control write with start code 1 (bits 26:24 = 1) and burst 0 while idle raises `conv_start_o` for exactly one cycle, in the cycle after the write. In that same cycle the start code reads back as 0.
- R3: With start code 0, no activity on any trigger line produces a start pulse.
- R4: Start code k, for k from 2 to 7, listens only to `trig_i[k-2]`. Indices 0 and 1 are the pins and indices 2 to 5 are the timer matches. An edge on any other line starts nothing.
- R5: With bit 27 = 0 a rising edge is selected, and with bit 27 = 1 a falling edge. The opposite edge starts nothing. The start pulse is visible in the third cycle after the line changes (two synchroniser stages and then the start register).
- R6: While burst (bit 16) is 1, neither start code 1 nor any trigger edge produces a start pulse, and a pending code 1 is kept.
- R7: A trigger edge that arrives while busy is high is dropped, not queued, and the hardware start code stays programmed.
- R8: The result becomes visible LAT+2 cycles after the start pulse: the done flags are set in the global register and in the register of the converted channel. The data equals `ana_i` in the start cycle. The global channel field holds the channel from control bits [CH_W-1:0] at the moment of the start.
- R9: A global read strobe clears the global done and overrun flags. A channel read strobe clears only the flags of the channel `rd_sel_i` selects.
- R10: A result that lands while its register still has done set makes that register's overrun flag 1. If the register was read before the next launch, the overrun flag stays 0.
- R11: If a read strobe and a result capture occur in the same cycle, the read returns the old data, and afterwards the register holds the new data with done 1 and overrun 0.
- R12: A result for one channel does not alter the data or flags of any other channel register, even though it overwrites the global register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 32 | Control word: start code 26:24, falling-edge select 27, burst 16, channel [CH_W-1:0] |
| trig_i | input | 6 | Asynchronous trigger lines: pins at 0 and 1, timer matches at 2 to 5 |
| ana_i | input | RES_W | Value the converter model samples at the start |
| rd_glb_i | input | 1 | Read strobe for the global register (clears its flags) |
| rd_chan_i | input | 1 | Read strobe for the selected channel register (clears its flags) |
| rd_sel_i | input | CH_W | Channel register shown on the ch_* outputs |
| conv_start_o | output | 1 | One-cycle conversion start pulse |
| busy_o | output | 1 | Conversion in flight, from the start pulse up to the result capture |
| start_mode_o | output | 3 | Current start code |
| glb_data_o | output | RES_W | Global result data |
| glb_chan_o | output | CH_W | Channel of the global result |
| glb_done_o | output | 1 | Global result unread |
| glb_ovr_o | output | 1 | Global result overwrote an unread one |
| ch_data_o | output | RES_W | Data of the selected channel register |
| ch_done_o | output | 1 | Done flag of the selected channel register |
| ch_ovr_o | output | 1 | Overrun flag of the selected channel register |

## Verification
Two events can land on the same clock edge: a read strobe that clears flags and a result capture that sets them. The bench counts cycles from the software start and raises both strobes exactly in the cycle when the converter model delivers its result, after first leaving an earlier result unread. The outcome is judged on three points: the data read in that cycle must be the old data, and afterwards the new data must sit with done set and overrun clear, in both the global register and the channel register. A second overlap is a trigger edge that arrives while a conversion is in flight. The bench judges it by the start-pulse count: the edge must not cause a second pulse, either at once or later.

// File: rtl/adc_start_pkg.sv
// Package: shared start-code encoding and control-word field positions.
// Assumes: hardware trigger k is reached by start code k+2.
package adc_start_pkg;

    localparam int START_LSB    = 24;
    localparam int EDGE_BIT     = 27;
    localparam int BURST_BIT    = 16;
    localparam int NUM_HW_TRIG  = 6;
    localparam int HW_CODE_BASE = 2;

    typedef enum logic [2:0] {
        START_NONE = 3'd0,
        START_NOW  = 3'd1,
        START_PIN0 = 3'd2,
        START_PIN1 = 3'd3,
        START_TMR0 = 3'd4,
        START_TMR1 = 3'd5,
        START_TMR2 = 3'd6,
        START_TMR3 = 3'd7
    } start_code_e;

    // Map a hardware start code onto its trigger line index.
    function automatic logic [2:0] trig_index(input logic [2:0] code);
        return code - 3'(HW_CODE_BASE);
    endfunction

endpackage

// File: rtl/adc_trig_edge.sv
// Module: adc_trig_edge
// Synchronises each asynchronous trigger line through two flops and
// detects the edge whose polarity fall_sel_i selects.
// Assumes: trigger lines sit low while reset is released, so that the
// synchroniser reset value does not fake an edge.
module adc_trig_edge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] trig_i,
    input  logic         fall_sel_i,
    output logic [N-1:0] edge_o
);

    for (genvar g = 0; g < N; g++) begin : g_line
        logic s1_q, s2_q, s3_q;

        // Two-stage synchroniser plus history flop for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
                s3_q <= 1'b0;
            end else begin
                s1_q <= trig_i[g];
                s2_q <= s1_q;
                s3_q <= s2_q;
            end
        end

        assign edge_o[g] = fall_sel_i ? (s3_q & ~s2_q) : (s2_q & ~s3_q);
    end

endmodule

// File: rtl/adc_conv_stub.sv
// Module: adc_conv_stub
// Behavioural stand-in for the analog converter: it samples ana_i and the
// channel at the start pulse and presents them LAT cycles later with a
// one-cycle valid.
// Assumes: LAT >= 1 and no start arrives while busy_o is high.
module adc_conv_stub #(
    parameter int LAT   = 11,
    parameter int RES_W = 10,
    parameter int CH_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CH_W-1:0]  chan_i,
    input  logic [RES_W-1:0] ana_i,
    output logic             busy_o,
    output logic             res_vld_o,
    output logic [RES_W-1:0] res_data_o,
    output logic [CH_W-1:0]  res_chan_o
);

    localparam int CNT_W = $clog2(LAT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [RES_W-1:0] data_q;
    logic [CH_W-1:0]  chan_q;
    logic             vld_q;

    // Latency counter and sample capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            data_q <= '0;
            chan_q <= '0;
        end else if (start_i) begin
            cnt_q  <= CNT_W'(LAT);
            data_q <= ana_i;
            chan_q <= chan_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    // One-cycle valid when the counter expires.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= (cnt_q == CNT_W'(1));
    end

    assign busy_o     = (cnt_q != '0) | vld_q;
    assign res_vld_o  = vld_q;
    assign res_data_o = data_q;
    assign res_chan_o = chan_q;

endmodule

// File: rtl/adc_result_bank.sv
// Module: adc_result_bank
// Holds the global result register and one register per channel, each
// with a done flag (cleared by its read strobe) and an overrun flag (set
// when a result replaces an unread one).
// Assumes: a read and a write in the same cycle count as the read first.
module adc_result_bank #(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    parameter int CH_W  = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [CH_W-1:0]  wr_chan_i,
    input  logic [RES_W-1:0] wr_data_i,
    input  logic             rd_glb_i,
    input  logic             rd_chan_i,
    input  logic [CH_W-1:0]  rd_sel_i,
    output logic [RES_W-1:0] glb_data_o,
    output logic [CH_W-1:0]  glb_chan_o,
    output logic             glb_done_o,
    output logic             glb_ovr_o,
    output logic [RES_W-1:0] ch_data_o,
    output logic             ch_done_o,
    output logic             ch_ovr_o
);

    logic [RES_W-1:0] glb_data_q;
    logic [CH_W-1:0]  glb_chan_q;
    logic             glb_done_q, glb_ovr_q;

    logic [RES_W-1:0] ch_data_q [NCH];
    logic [NCH-1:0]   ch_done_q;
    logic [NCH-1:0]   ch_ovr_q;

    // Global register: capture, read-clear, overrun tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glb_data_q <= '0;
            glb_chan_q <= '0;
            glb_done_q <= 1'b0;
            glb_ovr_q  <= 1'b0;
        end else if (wr_i) begin
            glb_data_q <= wr_data_i;
            glb_chan_q <= wr_chan_i;
            glb_done_q <= 1'b1;
            glb_ovr_q  <= glb_done_q & ~rd_glb_i;
        end else if (rd_glb_i) begin
            glb_done_q <= 1'b0;
            glb_ovr_q  <= 1'b0;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        logic wr_hit, rd_hit;
        assign wr_hit = wr_i && (wr_chan_i == CH_W'(g));
        assign rd_hit = rd_chan_i && (rd_sel_i == CH_W'(g));

        // Per-channel register with the same capture and clear rules.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ch_data_q[g] <= '0;
                ch_done_q[g] <= 1'b0;
                ch_ovr_q[g]  <= 1'b0;
            end else if (wr_hit) begin
                ch_data_q[g] <= wr_data_i;
                ch_done_q[g] <= 1'b1;
                ch_ovr_q[g]  <= ch_done_q[g] & ~rd_hit;
            end else if (rd_hit) begin
                ch_done_q[g] <= 1'b0;
                ch_ovr_q[g]  <= 1'b0;
            end
        end
    end

    assign glb_data_o = glb_data_q;
    assign glb_chan_o = glb_chan_q;
    assign glb_done_o = glb_done_q;
    assign glb_ovr_o  = glb_ovr_q;
    assign ch_data_o  = ch_data_q[rd_sel_i];
    assign ch_done_o  = ch_done_q[rd_sel_i];
    assign ch_ovr_o   = ch_ovr_q[rd_sel_i];

endmodule

// File: rtl/adc_start_ctl.sv
// Module: adc_start_ctl (top)
// Holds the control word and chooses, from the start code, between an
// immediate start and an edge on one of six synchronised trigger lines.
// It issues a one-cycle start pulse, runs the converter model and stores
// results in the global and per-channel registers.
// Assumes: NCH >= 2; burst only blocks starts, it does not scan.
module adc_start_ctl #(
    parameter int NCH   = 8,
    parameter int RES_W = 10,
    parameter int LAT   = 11,
    parameter int CH_W  = $clog2(NCH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_i,
    input  logic [31:0]      ctl_wdata_i,
    input  logic [5:0]       trig_i,
    input  logic [RES_W-1:0] ana_i,
    input  logic             rd_glb_i,
    input  logic             rd_chan_i,
    input  logic [CH_W-1:0]  rd_sel_i,
    output logic             conv_start_o,
    output logic             busy_o,
    output logic [2:0]       start_mode_o,
    output logic [RES_W-1:0] glb_data_o,
    output logic [CH_W-1:0]  glb_chan_o,
    output logic             glb_done_o,
    output logic             glb_ovr_o,
    output logic [RES_W-1:0] ch_data_o,
    output logic             ch_done_o,
    output logic             ch_ovr_o
);
    import adc_start_pkg::*;

    logic [2:0]       mode_q;
    logic             fall_q;
    logic             burst_q;
    logic [CH_W-1:0]  chan_q;
    logic [CH_W-1:0]  start_chan_q;
    logic             conv_start_q;
    logic [NUM_HW_TRIG-1:0] edge_w;
    logic             hw_hit;
    logic             fire;
    logic             stub_busy;
    logic             busy_w;
    logic             res_vld_w;
    logic [RES_W-1:0] res_data_w;
    logic [CH_W-1:0]  res_chan_w;
    logic             ctl_unused;

    assign ctl_unused = ^{ctl_wdata_i[31:28], ctl_wdata_i[23:17],
                          ctl_wdata_i[15:CH_W]};

    adc_trig_edge #(.N(NUM_HW_TRIG)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_i),
        .fall_sel_i (fall_q),
        .edge_o     (edge_w)
    );

    // Pick the edge of the trigger line the start code addresses.
    always_comb begin
        hw_hit = 1'b0;
        if (mode_q >= 3'(HW_CODE_BASE)) hw_hit = edge_w[trig_index(mode_q)];
    end

    assign busy_w = conv_start_q | stub_busy;
    assign fire   = !burst_q && !busy_w &&
                    ((mode_q == START_NOW) || hw_hit);

    // Control word register; code 1 clears itself once it fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= START_NONE;
            fall_q  <= 1'b0;
            burst_q <= 1'b0;
            chan_q  <= '0;
        end else if (ctl_wr_i) begin
            mode_q  <= ctl_wdata_i[START_LSB +: 3];
            fall_q  <= ctl_wdata_i[EDGE_BIT];
            burst_q <= ctl_wdata_i[BURST_BIT];
            chan_q  <= ctl_wdata_i[CH_W-1:0];
        end else if (fire && mode_q == START_NOW) begin
            mode_q <= START_NONE;
        end
    end

    // Start pulse register and the channel that goes with it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            conv_start_q <= 1'b0;
            start_chan_q <= '0;
        end else begin
            conv_start_q <= fire;
            if (fire) start_chan_q <= chan_q;
        end
    end

    adc_conv_stub #(.LAT(LAT), .RES_W(RES_W), .CH_W(CH_W)) u_conv (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (conv_start_q),
        .chan_i     (start_chan_q),
        .ana_i      (ana_i),
        .busy_o     (stub_busy),
        .res_vld_o  (res_vld_w),
        .res_data_o (res_data_w),
        .res_chan_o (res_chan_w)
    );

    adc_result_bank #(.NCH(NCH), .RES_W(RES_W), .CH_W(CH_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (res_vld_w),
        .wr_chan_i  (res_chan_w),
        .wr_data_i  (res_data_w),
        .rd_glb_i   (rd_glb_i),
        .rd_chan_i  (rd_chan_i),
        .rd_sel_i   (rd_sel_i),
        .glb_data_o (glb_data_o),
        .glb_chan_o (glb_chan_o),
        .glb_done_o (glb_done_o),
        .glb_ovr_o  (glb_ovr_o),
        .ch_data_o  (ch_data_o),
        .ch_done_o  (ch_done_o),
        .ch_ovr_o   (ch_ovr_o)
    );

    assign conv_start_o = conv_start_q;
    assign busy_o       = busy_w;
    assign start_mode_o = mode_q;

endmodule

// File: rtl/adc_start_chk.sv
// Module: adc_start_chk
// Temporal checks on the start controller, attached through bind.
module adc_start_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       conv_start,
    input logic       busy,
    input logic       burst,
    input logic       res_vld,
    input logic       rd_glb,
    input logic       glb_done,
    input logic       glb_ovr,
    input logic [2:0] mode,
    input logic       ctl_wr
);

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    a_r2_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start && $past(mode) == 3'd1 && !$past(ctl_wr)) |-> mode == 3'd0);

    a_r6_burst_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(burst));

    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> !$past(busy));

    a_r8_capture_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
        res_vld |=> glb_done);

    a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_glb && !res_vld) |=> (!glb_done && !glb_ovr));

    a_r10_ovr_needs_unread: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(glb_ovr) |-> $past(glb_done));

    a_r11_read_and_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_glb && res_vld) |=> (glb_done && !glb_ovr));

endmodule

bind adc_start_ctl adc_start_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .conv_start (conv_start_o),
    .busy       (busy_o),
    .burst      (burst_q),
    .res_vld    (res_vld_w),
    .rd_glb     (rd_glb_i),
    .glb_done   (glb_done_o),
    .glb_ovr    (glb_ovr_o),
    .mode       (start_mode_o),
    .ctl_wr     (ctl_wr_i)
);

// File: tb/sim_adc_start_ctl.sv
// Bench for adc_start_ctl: sweeps every hardware start code against both
// edge polarities, then checks software start, burst, busy, overrun and
// the read/capture overlap. Inputs change and outputs are sampled at the
// falling clock edge.
module sim_adc_start_ctl;
    localparam int NCH = 8, RES_W = 10, LAT = 11, CH_W = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [5:0] trig = '0;
    logic [RES_W-1:0] ana = '0;
    logic rd_glb = 1'b0, rd_chan = 1'b0;
    logic [CH_W-1:0] rd_sel = '0;
    logic conv_start, busy, glb_done, glb_ovr, ch_done, ch_ovr;
    logic [2:0] start_mode;
    logic [RES_W-1:0] glb_data, ch_data;
    logic [CH_W-1:0] glb_chan;

    int n_chk = 0, n_fail = 0, n_starts = 0;

    always #4 clk = ~clk;

    adc_start_ctl #(.NCH(NCH), .RES_W(RES_W), .LAT(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wdata),
        .trig_i(trig), .ana_i(ana), .rd_glb_i(rd_glb), .rd_chan_i(rd_chan),
        .rd_sel_i(rd_sel), .conv_start_o(conv_start), .busy_o(busy),
        .start_mode_o(start_mode), .glb_data_o(glb_data), .glb_chan_o(glb_chan),
        .glb_done_o(glb_done), .glb_ovr_o(glb_ovr), .ch_data_o(ch_data),
        .ch_done_o(ch_done), .ch_ovr_o(ch_ovr));

    // Count issued start pulses (value settled before each rising edge).
    always @(posedge clk) if (rst_n && conv_start) n_starts++;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic eq(input string tag, input int act, input int exp);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic step(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] cw(input int code, input bit fall,
                                       input bit burst, input int ch);
        return (32'(code) << 24) | (32'(fall) << 27) | (32'(burst) << 16) | 32'(ch);
    endfunction

    task automatic wr_ctl(input logic [31:0] w);
        ctl_wdata = w; ctl_wr = 1'b1; step(); ctl_wr = 1'b0;
    endtask

    task automatic rd_g();
        rd_glb = 1'b1; step(); rd_glb = 1'b0;
    endtask

    task automatic rd_c(input int c);
        rd_sel = CH_W'(c); rd_chan = 1'b1; step(); rd_chan = 1'b0;
    endtask

    // Software start; returns when the result is first visible.
    task automatic sw_conv(input int ch, input int val);
        ana = RES_W'(val);
        wr_ctl(cw(1, 0, 0, ch));
        step(LAT + 3);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int n0;
        step(4);
        rst_n = 1'b1;
        step();
        // R1 reset state
        eq("R1 conv_start", conv_start, 0);
        eq("R1 busy", busy, 0);
        eq("R1 start_mode", start_mode, 0);
        eq("R1 glb_done", glb_done, 0);
        eq("R1 glb_ovr", glb_ovr, 0);
        for (int c = 0; c < NCH; c++) begin
            rd_sel = CH_W'(c); #1;
            eq("R1 ch_done", ch_done, 0);
            eq("R1 ch_ovr", ch_ovr, 0);
        end

        // R3 code 0 ignores every trigger line
        n0 = n_starts;
        trig = 6'h3F; step(5); trig = '0; step(5);
        eq("R3 no start on code 0", n_starts, n0);

        // R2 software start, one pulse, self clear; R8 result; R9 clears
        ana = 10'h155;
        wr_ctl(cw(1, 0, 0, 3));
        eq("R2 no pulse in write cycle", conv_start, 0);
        eq("R2 code reads 1", start_mode, 1);
        step();
        eq("R2 pulse", conv_start, 1);
        eq("R2 self clear", start_mode, 0);
        step();
        eq("R2 pulse one cycle", conv_start, 0);
        step(LAT);
        eq("R8 not yet done", glb_done, 0);
        step();
        eq("R8 glb_done", glb_done, 1);
        eq("R8 glb_data", glb_data, 'h155);
        eq("R8 glb_chan", glb_chan, 3);
        rd_sel = 3'd3; #1;
        eq("R8 ch_done", ch_done, 1);
        eq("R8 ch_data", ch_data, 'h155);
        rd_g();
        eq("R9 glb read clears", glb_done, 0);
        rd_sel = 3'd3; #1;
        eq("R9 channel untouched by global read", ch_done, 1);
        rd_c(3);
        eq("R9 channel read clears", ch_done, 0);

        // R10 overrun on unread overwrite
        sw_conv(3, 'h0AA);
        eq("R10 first result no ovr", glb_ovr, 0);
        sw_conv(3, 'h0BB);
        eq("R10 glb_ovr", glb_ovr, 1);
        eq("R10 data replaced", glb_data, 'h0BB);
        rd_sel = 3'd3; #1;
        eq("R10 ch_ovr", ch_ovr, 1);
        rd_g(); rd_c(3);
        eq("R9 ovr cleared by read", glb_ovr, 0);
        sw_conv(3, 'h0CC);
        eq("R10 read before launch keeps ovr 0", glb_ovr, 0);
        rd_g(); rd_c(3);

        // R11 read strobe in the capture cycle
        sw_conv(2, 'h011);
        ana = 10'h022;
        wr_ctl(cw(1, 0, 0, 2));
        step();
        eq("R11 pulse", conv_start, 1);
        step(LAT + 1);
        eq("R11 read sees old data", glb_data, 'h011);
        rd_sel = 3'd2; rd_glb = 1'b1; rd_chan = 1'b1;
        step();
        rd_glb = 1'b0; rd_chan = 1'b0;
        eq("R11 glb_done", glb_done, 1);
        eq("R11 glb_ovr", glb_ovr, 0);
        eq("R11 new data", glb_data, 'h022);
        #1;
        eq("R11 ch_done", ch_done, 1);
        eq("R11 ch_ovr", ch_ovr, 0);
        rd_g(); rd_c(2);

        // R12 channel independence
        sw_conv(5, 'h055);
        sw_conv(6, 'h066);
        eq("R12 global holds ch6", glb_chan, 6);
        eq("R12 global overrun", glb_ovr, 1);
        rd_sel = 3'd5; #1;
        eq("R12 ch5 data kept", ch_data, 'h055);
        eq("R12 ch5 done", ch_done, 1);
        eq("R12 ch5 no ovr", ch_ovr, 0);
        rd_sel = 3'd6; #1;
        eq("R12 ch6 data", ch_data, 'h066);
        rd_g(); rd_c(5); rd_c(6);

        // R6 burst blocks every start source
        n0 = n_starts;
        wr_ctl(cw(1, 0, 1, 0));
        step(6);
        eq("R6 code 1 held under burst", start_mode, 1);
        wr_ctl(cw(2, 0, 1, 0));
        trig[0] = 1'b1; step(6); trig[0] = 1'b0; step(4);
        eq("R6 no start under burst", n_starts, n0);
        wr_ctl(cw(0, 0, 0, 0));
        step(4);

        // R4/R5 sweep of hardware codes and polarities
        for (int code = 2; code <= 7; code++) begin
            for (int pol = 0; pol < 2; pol++) begin
                int idx, other, first, dn;
                idx = code - 2;
                other = (idx + 1) % 6;
                wr_ctl(cw(0, 0, 0, 0));
                trig = pol ? 6'h3F : 6'h00; step(4);
                trig[idx] = ~pol[0]; step(4);
                n0 = n_starts;
                wr_ctl(cw(code, pol[0], 0, idx));
                trig[idx] = pol[0]; step(5);
                trig[other] = ~pol[0]; step(5);
                trig[other] = pol[0]; step(5);
                eq("R5 opposite edge / R4 other line ignored", n_starts, n0);
                ana = RES_W'(code * 16 + pol);
                trig[idx] = ~pol[0];
                first = -1; dn = -1;
                for (int k = 1; k <= LAT + 8; k++) begin
                    step();
                    if (conv_start && first < 0) first = k;
                    if (glb_done && dn < 0) dn = k;
                end
                eq("R5 trigger to start latency", first, 3);
                eq("R8 start to done latency", dn - first, LAT + 2);
                eq("R4 data", glb_data, code * 16 + pol);
                eq("R4 chan", glb_chan, idx);
                eq("R4 one start", n_starts, n0 + 1);
                rd_g(); rd_c(idx);
            end
        end
        wr_ctl(cw(0, 0, 0, 0));
        trig = '0; step(4);

        // R7 edge during busy is dropped
        n0 = n_starts;
        ana = 10'h077;
        wr_ctl(cw(1, 0, 0, 1));
        step();
        wr_ctl(cw(2, 0, 0, 1));
        trig[0] = 1'b1; step(4); trig[0] = 1'b0;
        step(LAT + 6);
        eq("R7 edge while busy ignored", n_starts, n0 + 1);
        eq("R7 code kept", start_mode, 2);
        trig[0] = 1'b1; step(6); trig[0] = 1'b0;
        eq("R7 later edge starts", n_starts, n0 + 2);
        step(LAT + 4);
        rd_g(); rd_c(1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule